// File: doc/BRIEF.md
# Buffered-Compare PWM Timer with Pulse Capture

This block is a 16-bit up-counter for pulse-width generation and pulse measurement. It counts from 1 up to a programmable wrap value, then returns to 1. A PWM output stays high while the count is below an active compare value. Software writes the compare value one byte at a time. While the timer runs, those writes can be held in a shadow register and applied together at the next wrap, so the PWM period never sees a half-updated value. A control bit turns this holding off and makes compare writes take effect at once.

The timer input pin goes through a synchronizer before edge detection. A qualifying edge copies the current count into a capture register and sets a sticky flag. A qualifying edge is either the one edge picked by the polarity input, or any edge when dual-edge mode is set. The counter can run on every system clock cycle. It can also advance only on cycles where a peripheral-clock enable strobe is high, which stands in for a slower peripheral clock in the same clock domain.

Top module: `pwm_cap_timer`

## Requirements
- R1: After reset, the control register reads 0x00, the count is 1, the compare value is 0, the capture value is 0, the capture flag is 0 and the PWM output is 0.
- R2: In the control register, only bit 0 (count-clock select), bit 4 (dual-edge capture) and bit 5 (compare-update bypass) can be written. Writing 0xFF reads back as 0x31.
- R3: While the timer enable is low, a write to either compare byte changes the active compare value at the next clock edge.
- R4: While the timer enable is high and bit 5 is 0, compare writes go only to the shadow. The active value takes the shadow value at the clock edge where the count reloads to 1.
- R5: While the timer enable is high and bit 5 is 1, compare writes change the active value at once, as in R3.
- R6: While enabled, each count step adds 1 until the count equals the wrap value, and the next step loads 1. While the enable is low, the count is forced to 1.
- R7: With bit 0 = 0 the counter steps on every clock edge. With bit 0 = 1 it steps only at edges where the peripheral-clock enable is high.
- R8: The PWM output is registered. After each clock edge it equals (count < active compare), using the values those held just before that edge.
- R9: With bit 4 = 0, only the edge chosen by the polarity input is captured (1 = rising, 0 = falling), and only while the timer is enabled. The opposite edge leaves the capture value and flag unchanged. An input level first sampled at edge k is captured at edge k+2, and the stored value is the count held between edges k+1 and k+2.
- R10: With bit 4 = 1, both rising and falling edges are captured, with the same timing as R9.
- R11: Qualifying edges on consecutive cycles each produce a capture, and the later count overwrites the earlier one.
- R12: The capture flag is set by every capture and stays set until any write to register 7 clears it. If a capture happens in the same cycle as the clear, the flag stays set.
- R13: Register addresses are: 0 control, 1 and 2 compare high and low, 3 and 4 wrap value high and low, 5 and 6 capture high and low, 7 status with the capture flag in bit 0. Read data shows the register at the read address one cycle after that address is presented. The compare addresses read the active value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_waddr | input | 3 | Write address |
| bus_wdata | input | 8 | Write data |
| bus_raddr | input | 3 | Read address |
| bus_rdata | output | 8 | Registered read data |
| tmr_en | input | 1 | Timer enable |
| pclk_en | input | 1 | Peripheral-clock enable strobe |
| cap_rise | input | 1 | Single-edge polarity: 1 = rising, 0 = falling |
| tmr_in | input | 1 | Asynchronous timer input pin |
| cnt_o | output | 16 | Current count |
| cap_val_o | output | 16 | Capture register |
| cap_flag_o | output | 1 | Sticky capture flag |
| pwm_o | output | 1 | PWM output |

## Verification
The bench uses the default 16-bit counter and a two-stage synchronizer. It programs a wrap value of 9 and a compare value of 5, so the counter wraps every few cycles and the PWM output goes high and low many times in a short run. With such a short period, shadow commits, forced reloads while disabled, and captures landing on each count value (including the wrap point) all occur within a few hundred cycles. A cycle-accurate reference in the bench tracks the synchronizer delay, so random input toggling, toggling on every cycle and random peripheral strobes can all be checked against exact expected counts.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  typedef enum logic [2:0] {
    A_CTL    = 3'd0,
    A_CMP_HI = 3'd1,
    A_CMP_LO = 3'd2,
    A_RLD_HI = 3'd3,
    A_RLD_LO = 3'd4,
    A_CAP_HI = 3'd5,
    A_CAP_LO = 3'd6,
    A_STAT   = 3'd7
  } reg_addr_e;

  localparam int CTL_SEL_BIT  = 0;
  localparam int CTL_DUAL_BIT = 4;
  localparam int CTL_UE_BIT   = 5;
  localparam logic [7:0] CTL_MASK = 8'h31;
endpackage

// File: rtl/tpc_regs.sv
module tpc_regs
  import tpc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RELOAD_INIT = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [2:0]       rd_addr,
  output logic [7:0]       rd_data,
  input  logic             tmr_en,
  input  logic             wrap_evt,
  input  logic [CNT_W-1:0] cap_val,
  input  logic             cap_flag,
  output logic             sel_pclk,
  output logic             dual_edge,
  output logic             upd_bypass,
  output logic [CNT_W-1:0] cmp_act,
  output logic [CNT_W-1:0] reload,
  output logic             flag_clr
);
  localparam int HI_W = CNT_W - 8;

  logic [7:0]       ctl_q;
  logic [CNT_W-1:0] cmp_sh;
  logic             wr_ctl, wr_cmp_hi, wr_cmp_lo, wr_rld_hi, wr_rld_lo;
  logic             direct;

  assign wr_ctl    = wr_en && (wr_addr == A_CTL);
  assign wr_cmp_hi = wr_en && (wr_addr == A_CMP_HI);
  assign wr_cmp_lo = wr_en && (wr_addr == A_CMP_LO);
  assign wr_rld_hi = wr_en && (wr_addr == A_RLD_HI);
  assign wr_rld_lo = wr_en && (wr_addr == A_RLD_LO);
  assign flag_clr  = wr_en && (wr_addr == A_STAT);

  assign sel_pclk   = ctl_q[CTL_SEL_BIT];
  assign dual_edge  = ctl_q[CTL_DUAL_BIT];
  assign upd_bypass = ctl_q[CTL_UE_BIT];
  assign direct     = !tmr_en || upd_bypass;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= 8'h00;
      cmp_sh  <= '0;
      cmp_act <= '0;
      reload  <= RELOAD_INIT;
    end else begin
      if (wr_ctl) ctl_q <= wr_data & CTL_MASK;
      if (wr_cmp_hi) cmp_sh[CNT_W-1:8] <= wr_data[HI_W-1:0];
      if (wr_cmp_lo) cmp_sh[7:0] <= wr_data;
      if (wrap_evt && !direct) cmp_act <= cmp_sh;
      if (direct && wr_cmp_hi) cmp_act[CNT_W-1:8] <= wr_data[HI_W-1:0];
      if (direct && wr_cmp_lo) cmp_act[7:0] <= wr_data;
      if (wr_rld_hi) reload[CNT_W-1:8] <= wr_data[HI_W-1:0];
      if (wr_rld_lo) reload[7:0] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= 8'h00;
    end else begin
      case (reg_addr_e'(rd_addr))
        A_CTL:    rd_data <= ctl_q;
        A_CMP_HI: rd_data <= 8'(cmp_act >> 8);
        A_CMP_LO: rd_data <= cmp_act[7:0];
        A_RLD_HI: rd_data <= 8'(reload >> 8);
        A_RLD_LO: rd_data <= reload[7:0];
        A_CAP_HI: rd_data <= 8'(cap_val >> 8);
        A_CAP_LO: rd_data <= cap_val[7:0];
        A_STAT:   rd_data <= {7'd0, cap_flag};
        default:  rd_data <= 8'h00;
      endcase
    end
  end

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == A_CTL) |=> ((rd_data & ~CTL_MASK) == 8'h00));

  a_r3_direct_low_byte: assert property (@(posedge clk) disable iff (rst)
    (wr_cmp_lo && !tmr_en) |=> (cmp_act[7:0] == $past(wr_data)));

  a_r4_shadow_holds: assert property (@(posedge clk) disable iff (rst)
    (tmr_en && !upd_bypass && !wrap_evt) |=> $stable(cmp_act));
endmodule

// File: rtl/tpc_counter.sv
module tpc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tmr_en,
  input  logic             sel_pclk,
  input  logic             pclk_en,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] cmp_act,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_evt,
  output logic             pwm
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic tick, adv;

  assign tick     = sel_pclk ? pclk_en : 1'b1;
  assign adv      = tmr_en && tick;
  assign wrap_evt = adv && (cnt >= reload);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= ONE;
      pwm <= 1'b0;
    end else begin
      if (!tmr_en)       cnt <= ONE;
      else if (wrap_evt) cnt <= ONE;
      else if (adv)      cnt <= cnt + ONE;
      pwm <= (cnt < cmp_act);
    end
  end

  a_r6_forced_one: assert property (@(posedge clk) disable iff (rst)
    !tmr_en |=> (cnt == ONE));

  a_r6_wraps_to_one: assert property (@(posedge clk) disable iff (rst)
    (tmr_en && tick && (cnt >= reload)) |=> (cnt == ONE));

  a_r7_waits_for_strobe: assert property (@(posedge clk) disable iff (rst)
    (tmr_en && sel_pclk && !pclk_en) |=> $stable(cnt));
endmodule

// File: rtl/tpc_capture.sv
module tpc_capture #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tin,
  input  logic             tmr_en,
  input  logic             dual_edge,
  input  logic             cap_rise,
  input  logic             flag_clr,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_flag
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q, cur, rise, fall, hit;

  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b0;
    else     sync_q[0] <= tin;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sync_q[g] <= 1'b0;
      else     sync_q[g] <= sync_q[g-1];
    end
  end

  assign cur  = sync_q[SYNC_STAGES-1];
  assign rise = cur && !prev_q;
  assign fall = !cur && prev_q;
  assign hit  = tmr_en && (dual_edge ? (rise || fall) : (cap_rise ? rise : fall));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      cap_val  <= '0;
      cap_flag <= 1'b0;
    end else begin
      prev_q <= cur;
      if (hit) cap_val <= cnt;
      if (hit)           cap_flag <= 1'b1;
      else if (flag_clr) cap_flag <= 1'b0;
    end
  end

  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (cap_flag && !flag_clr) |=> cap_flag);

  a_r9_no_capture_when_off: assert property (@(posedge clk) disable iff (rst)
    !tmr_en |=> $stable(cap_val));

  a_r11_every_hit_flags: assert property (@(posedge clk) disable iff (rst)
    hit |=> cap_flag);
endmodule

// File: rtl/pwm_cap_timer.sv
module pwm_cap_timer
  import tpc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] RELOAD_INIT = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [2:0]       bus_waddr,
  input  logic [7:0]       bus_wdata,
  input  logic [2:0]       bus_raddr,
  output logic [7:0]       bus_rdata,
  input  logic             tmr_en,
  input  logic             pclk_en,
  input  logic             cap_rise,
  input  logic             tmr_in,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_flag_o,
  output logic             pwm_o
);
  logic             sel_pclk, dual_edge, upd_bypass, flag_clr, wrap_evt;
  logic [CNT_W-1:0] cmp_act, reload;

  tpc_regs #(.CNT_W(CNT_W), .RELOAD_INIT(RELOAD_INIT)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr), .wr_addr(bus_waddr), .wr_data(bus_wdata),
    .rd_addr(bus_raddr), .rd_data(bus_rdata),
    .tmr_en(tmr_en), .wrap_evt(wrap_evt),
    .cap_val(cap_val_o), .cap_flag(cap_flag_o),
    .sel_pclk(sel_pclk), .dual_edge(dual_edge), .upd_bypass(upd_bypass),
    .cmp_act(cmp_act), .reload(reload), .flag_clr(flag_clr)
  );

  tpc_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .tmr_en(tmr_en),
    .sel_pclk(sel_pclk), .pclk_en(pclk_en),
    .reload(reload), .cmp_act(cmp_act),
    .cnt(cnt_o), .wrap_evt(wrap_evt), .pwm(pwm_o)
  );

  tpc_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_capture (
    .clk(clk), .rst(rst), .tin(tmr_in), .tmr_en(tmr_en),
    .dual_edge(dual_edge), .cap_rise(cap_rise), .flag_clr(flag_clr),
    .cnt(cnt_o), .cap_val(cap_val_o), .cap_flag(cap_flag_o)
  );
endmodule

// File: tb/pwm_cap_timer_bench.sv
module pwm_cap_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_waddr = 3'd0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [2:0]  bus_raddr = 3'd0;
  logic [7:0]  bus_rdata;
  logic        tmr_en = 1'b0, pclk_en = 1'b0, cap_rise = 1'b1, tmr_in = 1'b0;
  logic [15:0] cnt_o, cap_val_o;
  logic        cap_flag_o, pwm_o;

  int n_chk = 0, n_bad = 0, m_chk = 0, m_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_cap_timer u_pwm_cap_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .tmr_en(tmr_en), .pclk_en(pclk_en), .cap_rise(cap_rise), .tmr_in(tmr_in),
    .cnt_o(cnt_o), .cap_val_o(cap_val_o), .cap_flag_o(cap_flag_o), .pwm_o(pwm_o)
  );

  // reference model state
  bit          mon_on = 0;
  bit          m_dual = 0, m_rise = 1, m_sel = 0;
  logic [15:0] m_reload = 16'd9, m_cmp = 16'd5;
  string       m_cap_tag = "R9";

  function automatic logic [15:0] next_count(logic [15:0] c, logic en, logic tk, logic [15:0] rl);
    if (!en) return 16'd1;
    if (!tk) return c;
    return (c >= rl) ? 16'd1 : c + 16'd1;
  endfunction

  function automatic logic edge_hit(logic en, logic dual, logic rise_sel, logic nw, logic old);
    if (!en) return 1'b0;
    if (dual) return nw != old;
    return rise_sel ? (nw && !old) : (!nw && old);
  endfunction

  task automatic mchk(string tag, logic [31:0] act, logic [31:0] exp);
    m_chk++;
    if (act !== exp) begin
      m_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  logic [3:0]  th = 4'd0;
  logic [15:0] last_cnt = 16'd1, m_cap = 16'd0, e_cnt = 16'd1;
  logic        m_flag = 1'b0, e_pwm = 1'b0, pend = 1'b0;

  always @(posedge clk or negedge clk) begin
    if (clk) begin
      th = {th[2:0], tmr_in};
      if (mon_on) begin
        if (edge_hit(tmr_en, m_dual, m_rise, th[2], th[3])) begin
          m_cap  = last_cnt;
          m_flag = 1'b1;
        end
        e_cnt = next_count(last_cnt, tmr_en, m_sel ? pclk_en : 1'b1, m_reload);
        e_pwm = last_cnt < m_cmp;
        pend  = 1'b1;
      end
    end else begin
      if (pend && mon_on) begin
        mchk(tmr_en ? (m_sel ? "R7 count" : "R6 count") : "R6 forced", cnt_o, e_cnt);
        mchk("R8 pwm", pwm_o, e_pwm);
        mchk(m_cap_tag, cap_val_o, m_cap);
        mchk("R12 flag", cap_flag_o, m_flag);
      end
      pend = 1'b0;
      if (!mon_on) begin
        m_cap  = cap_val_o;
        m_flag = cap_flag_o;
      end
      last_cnt = cnt_o;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_raddr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pause_mon();
    mon_on = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic run_rand(int n, int tin_pct, int pclk_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (($urandom % 100) < tin_pct) tmr_in = !tmr_in;
      pclk_en = (($urandom % 100) < pclk_pct);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk + m_chk, n_bad + m_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", cnt_o, 16'd1);
    chk("R1 flag", cap_flag_o, 1'b0);
    chk("R1 capture", cap_val_o, 16'd0);
    chk("R1 pwm", pwm_o, 1'b0);
    rd(3'd0, d); chk("R1 control", d, 8'h00);
    rd(3'd2, d); chk("R1 compare", d, 8'h00);

    // R2 reserved bits
    wr(3'd0, 8'hFF);
    rd(3'd0, d); chk("R2 control mask", d, 8'h31);
    wr(3'd0, 8'h00);

    // R3 direct compare write while disabled, R13 map
    wr(3'd1, 8'h00); wr(3'd2, 8'h05);
    rd(3'd2, d); chk("R3 compare lo", d, 8'h05);
    rd(3'd1, d); chk("R3 compare hi", d, 8'h00);
    wr(3'd3, 8'h00); wr(3'd4, 8'h09);
    rd(3'd4, d); chk("R13 wrap lo", d, 8'h09);
    wr(3'd7, 8'h00);

    // Phase A: rising single edge
    cap_rise = 1'b1; m_rise = 1; m_dual = 0; m_sel = 0; m_cap_tag = "R9 rise";
    tmr_en = 1'b1; mon_on = 1;
    for (int i = 0; i < 8; i++) begin
      repeat (5 + i) @(negedge clk);
      tmr_in = !tmr_in;
    end
    run_rand(60, 30, 0);

    // Phase B: falling single edge
    @(negedge clk);
    cap_rise = 1'b0; m_rise = 0; m_cap_tag = "R9 fall";
    run_rand(60, 30, 0);

    // Phase C: dual edge, then edges on every cycle
    pause_mon();
    wr(3'd0, 8'h10);
    m_dual = 1; m_cap_tag = "R10 dual"; mon_on = 1;
    run_rand(60, 30, 0);
    m_cap_tag = "R11 back-to-back";
    run_rand(12, 100, 0);

    // Phase D: peripheral clock strobe, with a disabled stretch
    pause_mon();
    wr(3'd0, 8'h11);
    m_sel = 1; m_cap_tag = "R10 dual pclk"; mon_on = 1;
    run_rand(50, 25, 35);
    @(negedge clk); tmr_en = 1'b0;
    run_rand(10, 40, 50);
    @(negedge clk); tmr_en = 1'b1;
    run_rand(40, 25, 35);

    // R12 clear and R13 capture readback
    pause_mon();
    rd(3'd7, d); chk("R13 status", d, {7'd0, cap_flag_o});
    rd(3'd6, d); chk("R13 capture lo", d, cap_val_o[7:0]);
    wr(3'd7, 8'hA5);
    @(negedge clk);
    chk("R12 cleared", cap_flag_o, 1'b0);
    rd(3'd7, d); chk("R12 status cleared", d, 8'h00);

    // R9 opposite edge ignored: falling edge with rising polarity
    wr(3'd0, 8'h00);
    cap_rise = 1'b1;
    tmr_in = 1'b1;
    repeat (5) @(negedge clk);
    wr(3'd7, 8'h00);
    d = cap_val_o[7:0];
    @(negedge clk); tmr_in = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 falling ignored flag", cap_flag_o, 1'b0);
    chk("R9 falling ignored value", cap_val_o[7:0], d);

    // R4 buffered compare update
    do @(negedge clk); while (cnt_o != 16'd1);
    wr(3'd2, 8'h07);
    rd(3'd2, d); chk("R4 held in shadow", d, 8'h05);
    do @(negedge clk); while (cnt_o != 16'd9);
    @(negedge clk);
    chk("R4 reload point", cnt_o, 16'd1);
    rd(3'd2, d); chk("R4 committed", d, 8'h07);

    // R5 bypass
    wr(3'd0, 8'h20);
    do @(negedge clk); while (cnt_o != 16'd1);
    wr(3'd2, 8'h03);
    rd(3'd2, d); chk("R5 immediate", d, 8'h03);

    // R8 pwm with the new compare value
    m_cmp = 16'd3; m_sel = 0; m_dual = 0; m_rise = 1; m_cap_tag = "R9 final";
    mon_on = 1;
    run_rand(30, 20, 0);
    mon_on = 0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk + m_chk, n_bad + m_bad);
    $finish;
  end
endmodule